// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the integer register file of a 32-bit core that runs in seven operating modes. It stores thirty 32-bit registers. Together with the program counter, which is supplied from outside, that gives thirty-one registers, and sixteen of them are visible at any one time. A 5-bit mode input chooses the physical register behind each logical index from 0 to 15:

- Every exception mode has its own stack pointer (logical 13) and its own link register (logical 14).
- The fast-interrupt mode also has private copies of logical 8 to 12.
- The privileged system mode works on the user registers.

The file has two registered read ports and one general write port. A second write port serves exception entry. It places a return address into the link register of a target mode that is given on its own input, whatever the current mode is. A read of logical 15 returns the external program-counter input. A write to logical 15 is discarded. Reads return the contents before any write that lands on the same edge, so the file has no internal bypass. A mode code that is not recognised falls back to the user registers and raises a flag.

Top module: `banked_gpr_file`

## Requirements
- R1: A synchronous active-high reset clears every stored register, both read outputs and the illegal-mode flag to zero.
- R2: In user mode, logical 0 to 14 select the user registers. System mode selects exactly the same registers, so a value written in one of these two modes reads back in the other.
- R3: In fast-interrupt mode, logical 8 to 14 select seven private registers, and writes there leave the user copies unchanged. Logical 0 to 7 stay shared with user mode.
- R4: Interrupt, supervisor, abort and undefined modes each own a private logical 13 and 14. They share logical 0 to 12 with user mode.
- R5: The mode codes are: user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011, system 5'b11111.
- R6: A read of logical index 4'hF returns the value of pc_i in the cycle the address was presented. A general write to index 4'hF changes no register.
- R7: Read data appears one clock after the address and mode are presented. It holds while the address, the mode and the stored contents do not change.
- R8: When a write and a read hit the same physical register in one cycle, the read returns the old contents. The new value is seen from the next read on.
- R9: With exc_en_i high, exc_lr_i is written to logical 14 of the mode on exc_mode_i, independent of mode_i.
- R10: When the exception port and the general write port hit the same physical register in one cycle, the exception value is kept. When they hit different registers, both writes take effect.
- R11: An unrecognised mode code, on either mode input, selects the user registers. For mode_i, illegal_mode_o goes high one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode |
| rd0_idx_i | input | 4 | Read port 0 logical index |
| rd1_idx_i | input | 4 | Read port 1 logical index |
| rd0_data_o | output | 32 | Read port 0 data, registered |
| rd1_data_o | output | 32 | Read port 1 data, registered |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write logical index |
| wr_data_i | input | 32 | General write data |
| exc_en_i | input | 1 | Exception-entry link write enable |
| exc_mode_i | input | 5 | Mode whose link register is written |
| exc_lr_i | input | 32 | Return address for the link register |
| pc_i | input | 32 | Program counter value returned for index 15 |
| illegal_mode_o | output | 1 | mode_i was not a recognised code, registered |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a general write and a read that resolve to the same physical register. The bench issues both in one cycle and expects the old contents. On the following cycle it expects the new value.

The second pair is the general write port and the exception link port. The bench drives both toward the interrupt-mode link register in one cycle, and the exception value must survive. It then drives them toward two different registers in one cycle, and both values must read back.

// File: rtl/bgpr_pkg.sv
package bgpr_pkg;
  localparam int MODE_W = 5;
  localparam int IDX_W  = 4;
  localparam int PHYS_N = 30;
  localparam int PHYS_W = $clog2(PHYS_N);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND
  } bank_e;

  // Physical layout: 0..14 user, 15..21 fast R8..R14, then pairs of R13/R14.
  localparam int FIQ_BASE = 15;
  localparam int IRQ_BASE = 22;
  localparam int SVC_BASE = 24;
  localparam int ABT_BASE = 26;
  localparam int UND_BASE = 28;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic bank_e bank_of(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(bank_e b, logic [IDX_W-1:0] idx);
    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] lo;
    lo = PHYS_W'(idx);
    if (idx < 4'd8 || idx == 4'd15) return (idx == 4'd15) ? '0 : lo;
    if (b == BK_FIQ) return PHYS_W'(FIQ_BASE) + lo - PHYS_W'(8);
    if (idx < 4'd13) return lo;
    case (b)
      BK_IRQ:  base = PHYS_W'(IRQ_BASE);
      BK_SVC:  base = PHYS_W'(SVC_BASE);
      BK_ABT:  base = PHYS_W'(ABT_BASE);
      BK_UND:  base = PHYS_W'(UND_BASE);
      default: return lo;
    endcase
    return base + lo - PHYS_W'(13);
  endfunction
endpackage

// File: rtl/bgpr_map.sv
module bgpr_map
  import bgpr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_pc_o
);
  bank_e bank;

  always_comb begin
    bank    = bank_of(mode_i);
    phys_o  = phys_of(bank, idx_i);
    is_pc_o = (idx_i == 4'hF);
  end
endmodule

// File: rtl/bgpr_store.sv
module bgpr_store #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 30,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic [AW-1:0]     wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [AW-1:0]     wa_b,
  input  logic [DATA_W-1:0] wd_b,
  input  logic [AW-1:0]     ra0,
  input  logic [AW-1:0]     ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Port b is written last so it wins on a shared address.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_a) mem[wa_a] <= wd_a;
      if (we_b) mem[wa_b] <= wd_b;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import bgpr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd0_idx_i,
  input  logic [3:0]        rd1_idx_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic [DATA_W-1:0] rd1_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              exc_en_i,
  input  logic [4:0]        exc_mode_i,
  input  logic [DATA_W-1:0] exc_lr_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic              illegal_mode_o
);
  // Lookup slots: 0 read0, 1 read1, 2 general write, 3 exception link.
  localparam int NLK    = 4;
  localparam int LK_RD0 = 0;
  localparam int LK_RD1 = 1;
  localparam int LK_WR  = 2;
  localparam int LK_EXC = 3;
  localparam logic [IDX_W-1:0] LR_IDX = 4'd14;

  logic [NLK-1:0][MODE_W-1:0] lk_mode;
  logic [NLK-1:0][IDX_W-1:0]  lk_idx;
  logic [NLK-1:0][PHYS_W-1:0] lk_phys;
  logic [NLK-1:0]             lk_pc;

  assign lk_mode = {exc_mode_i, mode_i, mode_i, mode_i};
  assign lk_idx  = {LR_IDX, wr_idx_i, rd1_idx_i, rd0_idx_i};

  for (genvar g = 0; g < NLK; g++) begin : g_map
    bgpr_map u_map (
      .mode_i (lk_mode[g]),
      .idx_i  (lk_idx[g]),
      .phys_o (lk_phys[g]),
      .is_pc_o(lk_pc[g])
    );
  end

  logic              gen_we, exc_we;
  logic [DATA_W-1:0] raw0, raw1;

  assign gen_we = wr_en_i && !lk_pc[LK_WR];
  assign exc_we = exc_en_i && !lk_pc[LK_EXC];

  bgpr_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N)) u_store (
    .clk (clk),
    .rst (rst),
    .we_a(gen_we),
    .wa_a(lk_phys[LK_WR]),
    .wd_a(wr_data_i),
    .we_b(exc_we),
    .wa_b(lk_phys[LK_EXC]),
    .wd_b(exc_lr_i),
    .ra0 (lk_phys[LK_RD0]),
    .ra1 (lk_phys[LK_RD1]),
    .rd0 (raw0),
    .rd1 (raw1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_data_o     <= '0;
      rd1_data_o     <= '0;
      illegal_mode_o <= 1'b0;
    end else begin
      rd0_data_o     <= lk_pc[LK_RD0] ? pc_i : raw0;
      rd1_data_o     <= lk_pc[LK_RD1] ? pc_i : raw1;
      illegal_mode_o <= !mode_known(mode_i);
    end
  end
endmodule

// File: rtl/bgpr_chk.sv
module bgpr_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd0_idx_i,
  input logic [3:0]        rd1_idx_i,
  input logic [DATA_W-1:0] rd0_data_o,
  input logic [DATA_W-1:0] rd1_data_o,
  input logic              wr_en_i,
  input logic              exc_en_i,
  input logic [DATA_W-1:0] pc_i,
  input logic              illegal_mode_o
);
  logic code_ok;
  assign code_ok = (mode_i inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F});

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd0_data_o == '0 && rd1_data_o == '0 && !illegal_mode_o));

  assert_pc_rd0_R6: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx_i == 4'hF) |=> (rd0_data_o == $past(pc_i)));

  assert_pc_rd1_R6: assert property (@(posedge clk) disable iff (rst)
    (rd1_idx_i == 4'hF) |=> (rd1_data_o == $past(pc_i)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !exc_en_i && rd0_idx_i != 4'hF) ##1
    (!wr_en_i && !exc_en_i && $stable(rd0_idx_i) && $stable(mode_i))
    |=> $stable(rd0_data_o));

  assert_illegal_flag_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (illegal_mode_o == !$past(code_ok)));
endmodule

bind banked_gpr_file bgpr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_i        (mode_i),
  .rd0_idx_i     (rd0_idx_i),
  .rd1_idx_i     (rd1_idx_i),
  .rd0_data_o    (rd0_data_o),
  .rd1_data_o    (rd1_data_o),
  .wr_en_i       (wr_en_i),
  .exc_en_i      (exc_en_i),
  .pc_i          (pc_i),
  .illegal_mode_o(illegal_mode_o)
);

// File: tb/banked_gpr_file_tb.sv
module banked_gpr_file_tb_top;
  localparam int DW = 32;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] mode = USR;
  logic [3:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd0_data, rd1_data, wr_data = '0, exc_lr = '0, pc = '0;
  logic wr_en = 1'b0, exc_en = 1'b0, illegal;
  logic [4:0] exc_mode = USR;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  banked_gpr_file #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode),
    .rd0_idx_i(rd0_idx), .rd1_idx_i(rd1_idx),
    .rd0_data_o(rd0_data), .rd1_data_o(rd1_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .exc_lr_i(exc_lr),
    .pc_i(pc), .illegal_mode_o(illegal)
  );

  typedef struct packed {
    logic [4:0]  mode;
    logic        we;
    logic [3:0]  idx;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{USR, 1'b1, 4'd0,  32'h0000_00A0, 1'b0, 32'h0, 4'd2},
    '{USR, 1'b1, 4'd8,  32'h0000_00A8, 1'b0, 32'h0, 4'd2},
    '{USR, 1'b1, 4'd13, 32'h0000_00AD, 1'b0, 32'h0, 4'd2},
    '{USR, 1'b1, 4'd14, 32'h0000_00AE, 1'b0, 32'h0, 4'd2},
    '{FIQ, 1'b1, 4'd8,  32'h0000_00F8, 1'b0, 32'h0, 4'd3},
    '{FIQ, 1'b1, 4'd13, 32'h0000_00FD, 1'b0, 32'h0, 4'd3},
    '{IRQ, 1'b1, 4'd13, 32'h0000_001D, 1'b0, 32'h0, 4'd4},
    '{SVC, 1'b1, 4'd13, 32'h0000_002D, 1'b0, 32'h0, 4'd4},
    '{ABT, 1'b1, 4'd14, 32'h0000_003E, 1'b0, 32'h0, 4'd4},
    '{UND, 1'b1, 4'd13, 32'h0000_004D, 1'b0, 32'h0, 4'd4},
    '{SYS, 1'b1, 4'd12, 32'h0000_005C, 1'b0, 32'h0, 4'd2},
    '{FIQ, 1'b1, 4'd9,  32'h0000_0099, 1'b0, 32'h0, 4'd3},
    // reads; every mode code of R5 appears
    '{USR, 1'b0, 4'd8,  32'h0, 1'b1, 32'h0000_00A8, 4'd3},  // R3 user copy kept
    '{FIQ, 1'b0, 4'd8,  32'h0, 1'b1, 32'h0000_00F8, 4'd3},  // R3
    '{FIQ, 1'b0, 4'd0,  32'h0, 1'b1, 32'h0000_00A0, 4'd3},  // R3 low shared
    '{FIQ, 1'b0, 4'd12, 32'h0, 1'b1, 32'h0000_0000, 4'd3},  // R3
    '{FIQ, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_00FD, 4'd3},  // R3
    '{USR, 1'b0, 4'd9,  32'h0, 1'b1, 32'h0000_0000, 4'd3},  // R3
    '{IRQ, 1'b0, 4'd8,  32'h0, 1'b1, 32'h0000_00A8, 4'd4},  // R4 shared
    '{IRQ, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_001D, 4'd4},  // R4
    '{SVC, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_002D, 4'd5},  // R5
    '{ABT, 1'b0, 4'd14, 32'h0, 1'b1, 32'h0000_003E, 4'd5},  // R5
    '{ABT, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_0000, 4'd4},  // R4
    '{UND, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_004D, 4'd5},  // R5
    '{UND, 1'b0, 4'd12, 32'h0, 1'b1, 32'h0000_005C, 4'd4},  // R4
    '{USR, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_00AD, 4'd2},  // R2
    '{SYS, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_00AD, 4'd2},  // R2
    '{USR, 1'b0, 4'd12, 32'h0, 1'b1, 32'h0000_005C, 4'd2},  // R2
    '{USR, 1'b0, 4'd14, 32'h0, 1'b1, 32'h0000_00AE, 4'd2},  // R2
    '{BAD, 1'b0, 4'd13, 32'h0, 1'b1, 32'h0000_00AD, 4'd11}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd0", rd0_data, '0);
    check("R1 rd1", rd1_data, '0);
    check("R1 flag", {31'b0, illegal}, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      mode    = TBL[i].mode;
      wr_en   = TBL[i].we;
      wr_idx  = TBL[i].idx;
      wr_data = TBL[i].data;
      rd0_idx = TBL[i].we ? 4'd0 : TBL[i].idx;
      step();
      if (TBL[i].chk) begin
        n_chk++;
        if (rd0_data !== TBL[i].exp) begin
          n_bad++;
          $display("FAIL R%0d vec %0d: got %h expected %h", TBL[i].req, i, rd0_data, TBL[i].exp);
        end
      end
    end
    wr_en = 1'b0;

    // R11 flag follows mode one cycle later
    mode = BAD; step();
    check("R11 flag high", {31'b0, illegal}, 32'd1);
    mode = USR; step();
    check("R11 flag low", {31'b0, illegal}, 32'd0);

    // R7 latency: output holds until the next edge
    rd0_idx = 4'd0; step();
    rd0_idx = 4'd8; #2;
    check("R7 before edge", rd0_data, 32'hA0);
    step();
    check("R7 after edge", rd0_data, 32'hA8);

    // R6 program counter on index 15
    pc = 32'hDEAD_BEEF; rd0_idx = 4'hF; rd1_idx = 4'hF; step();
    check("R6 rd0 pc", rd0_data, 32'hDEAD_BEEF);
    check("R6 rd1 pc", rd1_data, 32'hDEAD_BEEF);
    pc = 32'h1234_5678; step();
    check("R6 pc follows", rd0_data, 32'h1234_5678);
    rd0_idx = 4'd0; wr_en = 1'b1; wr_idx = 4'hF; wr_data = 32'hFFFF_FFFF; step();
    wr_en = 1'b0; step();
    check("R6 write15 ignored", rd0_data, 32'hA0);
    check("R6 rd1 still pc", rd1_data, 32'h1234_5678);

    // R8 same-cycle write and read: old value, then new
    rd1_idx = 4'd1; wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h111; step();
    check("R8 old value", rd1_data, 32'h0);
    wr_en = 1'b0; step();
    check("R8 new value", rd1_data, 32'h111);

    // R9 exception link to another mode
    mode = USR; exc_en = 1'b1; exc_mode = SVC; exc_lr = 32'hCAFE; step();
    exc_en = 1'b0; mode = SVC; rd0_idx = 4'd14; step();
    check("R9 target link", rd0_data, 32'hCAFE);
    mode = USR; step();
    check("R9 user link kept", rd0_data, 32'hAE);

    // R10 both write ports on the same register
    mode = IRQ; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1;
    exc_en = 1'b1; exc_mode = IRQ; exc_lr = 32'h2; step();
    wr_en = 1'b0; exc_en = 1'b0; rd0_idx = 4'd14; step();
    check("R10 exception wins", rd0_data, 32'h2);
    // R10 both write ports on different registers
    mode = USR; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3;
    exc_en = 1'b1; exc_mode = ABT; exc_lr = 32'h4; step();
    wr_en = 1'b0; exc_en = 1'b0; rd0_idx = 4'd3; step();
    check("R10 general write", rd0_data, 32'h3);
    mode = ABT; rd0_idx = 4'd14; step();
    check("R10 exception write", rd0_data, 32'h4);

    // R11 unknown exception target falls back to user link
    mode = USR; exc_en = 1'b1; exc_mode = 5'b00000; exc_lr = 32'h77; step();
    exc_en = 1'b0; rd0_idx = 4'd14; step();
    check("R11 unknown target", rd0_data, 32'h77);

    // R1 reset during operation clears storage
    rst = 1'b1; step(); step();
    check("R1 outputs cleared", rd0_data, 32'h0);
    rst = 1'b0; rd0_idx = 4'd0; step();
    check("R1 storage cleared", rd0_data, 32'h0);

    finish_run();
  end
endmodule